// File: doc/BRIEF.md
# Banked Pin Configuration Register Array

This block stores the configuration of a small group of general-purpose pins. Every pin owns exactly one byte-wide location on a simple byte bus. Behind that one location sit six 4-bit configuration banks. A byte written to a pin's location names a bank in bits 6:4. Bit 7 of that byte decides between two actions. When it is set, bits 3:0 are stored into the named bank. When it is clear, the byte only chooses which bank a later read of that location shows.

The stored fields are decoded into per-pin pad controls: output enable, output value, open-drain select and pin disable. Each pin also has a real-time level bit. In output mode that bit repeats the programmed output value. In every other mode it shows the pad input after a two-flop synchronizer. The remaining fields have no logic behind them here and are exported raw: supply select, mode enable, pull code, drive strength, alternate function and interrupt polarity.

Top module: `pin_cfg_bank_array`

## Requirements
- R1: A write whose bit 7 is 1 and whose bits 6:4 hold a bank number 0..5 stores bits 3:0 into that bank of the addressed pin and makes that bank the pin's selected bank.
- R2: A write whose bit 7 is 0 stores nothing; bits 6:4 (0..5) only become the pin's selected bank.
- R3: A write naming bank 6 or 7 is ignored entirely: no bank changes and the selection is kept.
- R4: A read strobe captures, at that clock edge, the byte {0, selected bank in bits 6:4, that bank's value in bits 3:0} of the addressed pin into bus_rdata, which holds between strobes. Addresses at or above NUM_PINS read 0x00 and ignore writes.
- R5: Reset clears every bank, every selection and bus_rdata to zero, so each pin is an input with its pad driver off.
- R6: The mode is bank 1 bits 3:2 (0 input, 1 input and output, 2 output, 3 off). pad_oe is 1 only for modes 1 and 2, and only while bank 3 bit 0 is 0.
- R7: pad_out is bank 1 bit 0, pad_od (1 = open-drain) is bank 1 bit 1, and pad_dis is bank 3 bit 0.
- R8: In mode 2, pin_level equals bank 1 bit 0. In other modes it follows pad_in through two flops: a change is not visible after one rising edge and is visible after the second.
- R9: The raw fields are exported per pin: supply_sel = bank 0 bits 3:1, mode_en = bank 0 bit 0, pull_cfg = bank 2 bits 3:1, drive_str = bank 3 bits 3:2, alt_func = bank 4 bits 3:1, irq_noninv = bank 5 bit 3.
- R10: Six back-to-back storing writes to one pin, one per bank, leave all six banks holding their values. Writes to one pin never change another pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Pin location |
| bus_wdata | input | 8 | Write byte: flag, bank, value |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read byte |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_out | output | NUM_PINS | Pad output value |
| pad_od | output | NUM_PINS | Open-drain select |
| pad_dis | output | NUM_PINS | Pin disable |
| pin_level | output | NUM_PINS | Real-time level status |
| supply_sel | output | 3*NUM_PINS | Raw supply select code |
| mode_en | output | NUM_PINS | Raw mode-enable flag |
| pull_cfg | output | 3*NUM_PINS | Raw pull code |
| drive_str | output | 2*NUM_PINS | Raw drive strength |
| alt_func | output | 3*NUM_PINS | Raw alternate function |
| irq_noninv | output | NUM_PINS | Non-inverted interrupt polarity |

## Verification
The bench interleaves storing writes and select-only writes, then reads back after each one. A design that stored data on a select-only write, or failed to move the selection, returns the wrong byte. Writes that name banks 6 and 7 are checked to change neither data nor selection, and an out-of-range pin address is checked to read zero and to leave the other pins alone. The enable logic is driven through all four modes and through the disable bit, so an output enable that ignores the disable bit or the both-directions mode shows up. The level bit is sampled one edge and two edges after an input change to find a synchronizer with the wrong depth. A six-write burst to one pin, followed by a read of each bank, finds writes that land in the wrong bank.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int BANKS  = 6;
  localparam int BANK_W = 4;
  localparam int SEL_W  = 3;
  localparam int FLAT_W = BANKS * BANK_W;

  typedef enum logic [1:0] {
    MODE_IN    = 2'd0,
    MODE_BIDIR = 2'd1,
    MODE_OUT   = 2'd2,
    MODE_OFF   = 2'd3
  } pin_mode_e;

  // pad driver on only for driving modes while the pin is enabled
  function automatic logic drives_pad(pin_mode_e m, logic dis);
    return ((m == MODE_OUT) || (m == MODE_BIDIR)) && !dis;
  endfunction

  function automatic logic [7:0] pack_read(logic [SEL_W-1:0] sel, logic [BANK_W-1:0] v);
    return {1'b0, sel, v};
  endfunction

  function automatic logic bank_valid(logic [SEL_W-1:0] b);
    return b < SEL_W'(BANKS);
  endfunction
endpackage

// File: rtl/pcb_pin_slot.sv
module pcb_pin_slot
  import pcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [7:0]        wdata,
  output logic [FLAT_W-1:0] banks_o,
  output logic [SEL_W-1:0]  sel_o
);
  logic [BANK_W-1:0] bank_q [BANKS];
  logic [SEL_W-1:0]  sel_q;

  wire [SEL_W-1:0] tgt    = wdata[6:4];
  wire             store  = wdata[7];
  wire             accept = wr_hit && bank_valid(tgt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      for (int k = 0; k < BANKS; k++) bank_q[k] <= '0;
    end else if (accept) begin
      sel_q <= tgt;
      for (int k = 0; k < BANKS; k++)
        if (store && (tgt == SEL_W'(k))) bank_q[k] <= wdata[BANK_W-1:0];
    end
  end

  for (genvar k = 0; k < BANKS; k++) begin : g_flat
    assign banks_o[k*BANK_W +: BANK_W] = bank_q[k];
  end
  assign sel_o = sel_q;
endmodule

// File: rtl/pcb_pad_decode.sv
module pcb_pad_decode
  import pcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAT_W-1:0] banks,
  input  logic              pad_in,
  output logic              oe,
  output logic              out_val,
  output logic              od,
  output logic              dis,
  output logic              level,
  output logic [2:0]        supply,
  output logic              men,
  output logic [2:0]        pull,
  output logic [1:0]        drive,
  output logic [2:0]        func,
  output logic              noninv
);
  wire [BANK_W-1:0] b0 = banks[0*BANK_W +: BANK_W];
  wire [BANK_W-1:0] b1 = banks[1*BANK_W +: BANK_W];
  wire [BANK_W-1:0] b2 = banks[2*BANK_W +: BANK_W];
  wire [BANK_W-1:0] b3 = banks[3*BANK_W +: BANK_W];
  wire [BANK_W-1:0] b4 = banks[4*BANK_W +: BANK_W];
  wire [BANK_W-1:0] b5 = banks[5*BANK_W +: BANK_W];

  pin_mode_e mode;
  assign mode = pin_mode_e'(b1[3:2]);

  logic sync1_q, sync2_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  assign dis     = b3[0];
  assign oe      = drives_pad(mode, b3[0]);
  assign out_val = b1[0];
  assign od      = b1[1];
  assign level   = (mode == MODE_OUT) ? b1[0] : sync2_q;
  assign supply  = b0[3:1];
  assign men     = b0[0];
  assign pull    = b2[3:1];
  assign drive   = b3[3:2];
  assign func    = b4[3:1];
  assign noninv  = b5[3];
endmodule

// File: rtl/pin_cfg_bank_array.sv
module pin_cfg_bank_array
  import pcb_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int ADDR_W   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [7:0]            bus_wdata,
  input  logic                  bus_we,
  input  logic                  bus_re,
  output logic [7:0]            bus_rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_od,
  output logic [NUM_PINS-1:0]   pad_dis,
  output logic [NUM_PINS-1:0]   pin_level,
  output logic [3*NUM_PINS-1:0] supply_sel,
  output logic [NUM_PINS-1:0]   mode_en,
  output logic [3*NUM_PINS-1:0] pull_cfg,
  output logic [2*NUM_PINS-1:0] drive_str,
  output logic [3*NUM_PINS-1:0] alt_func,
  output logic [NUM_PINS-1:0]   irq_noninv
);
  logic [NUM_PINS-1:0] wr_hit;
  logic [FLAT_W-1:0]   banks_w [NUM_PINS];
  logic [SEL_W-1:0]    sel_w   [NUM_PINS];
  logic [7:0]          rd_next;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign wr_hit[g] = bus_we && (bus_addr == ADDR_W'(g));

    pcb_pin_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (wr_hit[g]),
      .wdata   (bus_wdata),
      .banks_o (banks_w[g]),
      .sel_o   (sel_w[g])
    );

    pcb_pad_decode u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .banks   (banks_w[g]),
      .pad_in  (pad_in[g]),
      .oe      (pad_oe[g]),
      .out_val (pad_out[g]),
      .od      (pad_od[g]),
      .dis     (pad_dis[g]),
      .level   (pin_level[g]),
      .supply  (supply_sel[3*g +: 3]),
      .men     (mode_en[g]),
      .pull    (pull_cfg[3*g +: 3]),
      .drive   (drive_str[2*g +: 2]),
      .func    (alt_func[3*g +: 3]),
      .noninv  (irq_noninv[g])
    );
  end

  // read mux: unmatched addresses leave zero
  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_PINS; i++)
      if (bus_addr == ADDR_W'(i))
        rd_next = pack_read(sel_w[i], banks_w[i][BANK_W*sel_w[i] +: BANK_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
  parameter int NUM_PINS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic                bus_re,
  input logic [7:0]          bus_rdata,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_od,
  input logic [NUM_PINS-1:0] pad_dis
);
  p_oe_off_when_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_dis) == '0);

  p_read_msb_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7] == 1'b0);

  p_read_bank_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[6:4] < 3'd6);

  p_read_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

  p_pads_hold_without_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable({pad_oe, pad_out, pad_od, pad_dis}));
endmodule

bind pin_cfg_bank_array pcb_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .pad_od    (pad_od),
  .pad_dis   (pad_dis)
);

// File: tb/tb_pin_cfg_bank_array.sv
module tb_pin_cfg_bank_array;
  localparam int N  = 4;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_oe, pad_out, pad_od, pad_dis, pin_level, mode_en, irq_noninv;
  logic [3*N-1:0] supply_sel, pull_cfg, alt_func;
  logic [2*N-1:0] drive_str;

  always #2.5 clk = ~clk;

  pin_cfg_bank_array #(.NUM_PINS(N), .ADDR_W(AW)) dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0;
  endtask

  // {addr, write byte, expected read byte after the write}
  localparam logic [18:0] VEC [12] = '{
    {3'd0, 8'h98, 8'h18},  // R1 store bank1=8
    {3'd0, 8'h23, 8'h20},  // R2 select bank2 only
    {3'd0, 8'h10, 8'h18},  // R2 back to bank1
    {3'd1, 8'hDF, 8'h5F},  // R1 bank5=F
    {3'd1, 8'hE5, 8'h5F},  // R3 bank6 store ignored
    {3'd1, 8'h75, 8'h5F},  // R3 bank7 select ignored
    {3'd2, 8'hBA, 8'h3A},  // R1 bank3=A
    {3'd3, 8'h87, 8'h07},  // R1 bank0=7
    {3'd5, 8'h91, 8'h00},  // R4 out of range
    {3'd0, 8'h30, 8'h30},  // R10 pin0 bank3 untouched
    {3'd3, 8'h00, 8'h07},  // R2 select bank0
    {3'd2, 8'hC6, 8'h46}   // R1 bank4=6
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5 reset state
    chk("R5 oe", pad_oe, 0);
    chk("R5 rdata", bus_rdata, 0);
    chk("R5 dis", pad_dis, 0);
    chk("R5 level", pin_level, 0);
    @(negedge clk); rst_n = 1'b1;
    rd(3'd2);
    chk("R5 read bank0", bus_rdata, 8'h00);

    // vector table: R1 R2 R3 R4 R10
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16]);
      chk($sformatf("R1|R2|R3|R4 vec %0d", i), bus_rdata, VEC[i][7:0]);
    end

    // R4 read data holds without strobe
    @(negedge clk); bus_addr = 3'd1;
    repeat (2) @(negedge clk);
    chk("R4 hold", bus_rdata, 8'h46);

    // R9 raw fields
    chk("R9 drive pin2", drive_str[5:4], 2'b10);
    chk("R9 func pin2", alt_func[8:6], 3'd3);
    chk("R9 supply pin3", supply_sel[11:9], 3'd3);
    chk("R9 mode_en pin3", mode_en[3], 1);
    chk("R9 noninv pin1", irq_noninv[1], 1);

    // R6 R7 R8 on pin0
    chk("R6 out mode oe", pad_oe[0], 1);
    wr(3'd0, 8'h9B);
    chk("R7 out", pad_out[0], 1);
    chk("R7 od", pad_od[0], 1);
    chk("R8 level in out mode", pin_level[0], 1);
    wr(3'd0, 8'hB1);
    chk("R6 disabled oe", pad_oe[0], 0);
    chk("R7 dis", pad_dis[0], 1);
    wr(3'd0, 8'hB0);
    chk("R6 re-enabled oe", pad_oe[0], 1);
    wr(3'd0, 8'h9C);
    chk("R6 off mode oe", pad_oe[0], 0);
    wr(3'd0, 8'h90);
    chk("R6 input mode oe", pad_oe[0], 0);
    wr(3'd0, 8'h94);
    chk("R6 bidir oe", pad_oe[0], 1);
    chk("R8 bidir level before", pin_level[0], 0);
    @(negedge clk); pad_in[0] = 1'b1;
    @(posedge clk); #1;
    chk("R8 one edge", pin_level[0], 0);
    @(posedge clk); #1;
    chk("R8 two edges", pin_level[0], 1);

    // R10 burst to pin3
    @(negedge clk); bus_addr = 3'd3; bus_we = 1'b1;
    for (int k = 0; k < 6; k++) begin
      bus_wdata = {1'b1, 3'(k), 4'(k + 9)};
      @(negedge clk);
    end
    bus_we = 1'b0;
    chk("R10 burst oe", pad_oe[3], 1);
    chk("R10 burst drive", drive_str[7:6], 2'b11);
    for (int k = 0; k < 6; k++) begin
      wr(3'd3, {1'b0, 3'(k), 4'h0});
      rd(3'd3);
      chk($sformatf("R10 bank %0d", k), bus_rdata, {1'b0, 3'(k), 4'(k + 9)});
    end
    wr(3'd2, 8'h30);
    rd(3'd2);
    chk("R10 pin2 untouched", bus_rdata, 8'h3A);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule